// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer half of a small accumulator machine. It holds a program counter, a memory address register, an instruction register, an accumulator, a temporary operand register, a subtracting ALU with a zero flag, and a 16-entry internal RAM. Everything moves over one shared 8-bit bus. An external microcoded sequencer steers it one clock at a time by raising transfer strobes. One group of strobes picks which source drives the bus, and the other group picks which registers capture it.

The instruction register's upper nibble is presented as an opcode and the zero flag as a status bit, so the sequencer can decode and branch. The lower nibble of the instruction is an address field that can be placed on the bus, zero-extended, to reach memory or to serve as a jump target. A dedicated conditional-jump strobe makes the block choose between loading that target into the program counter and simply stepping it, based on the stored zero flag. The RAM starts from a parameter image, and a reset leaves its contents alone.

Top module: `acc_bus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, PC, MAR, IR, ACC, TEMP and the zero flag all become 0 at that edge; RAM contents are not changed by reset.
- R2: Bus sources are PC (`pc_drv`), RAM at the MAR address (`mem_drv`), the IR address field (`ira_drv`), ACC (`acc_drv`) and the ALU result (`alu_drv`). At most one source is expected to be active in a cycle, and `bus_o` then carries its value. With no source active, `bus_o` is 0. If several sources are raised, the one earliest in that list wins.
- R3: When the IR address field drives the bus, `bus_o` is IR bits [3:0] with bits [7:4] zero.
- R4: `ir_ld` captures the bus into IR at the edge. `opcode_o` is always IR bits [7:4]. A two-cycle fetch (PC drive with MAR load, then RAM drive with IR load) places the RAM byte at the PC address into IR.
- R5: `pc_step` without `jz_go` adds 1 to PC, wrapping modulo 256.
- R6: The ALU result is (ACC − TEMP) mod 256. At an edge with `alu_drv` high, the zero flag becomes 1 if that result is 0 and becomes 0 otherwise. In every other cycle the zero flag holds its value.
- R7: With `jz_go` high, PC takes the zero-extended IR address field if the zero flag held before the edge is 1, and PC+1 otherwise. `jz_go` takes precedence over `pc_step`.
- R8: `mem_wr` writes the bus value into RAM at MAR bits [3:0]. MAR bits [7:4] play no part in RAM addressing, for either reads or writes.
- R9: `mar_ld`, `acc_ld` and `tmp_ld` each capture the bus value of that cycle into their register at the edge. The loads are independent, so several registers may capture the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_drv | input | 1 | PC drives the bus |
| pc_step | input | 1 | Increment PC |
| mar_ld | input | 1 | MAR captures the bus |
| mem_drv | input | 1 | RAM[MAR] drives the bus |
| mem_wr | input | 1 | RAM[MAR] captures the bus |
| ir_ld | input | 1 | IR captures the bus |
| acc_ld | input | 1 | ACC captures the bus |
| acc_drv | input | 1 | ACC drives the bus |
| tmp_ld | input | 1 | TEMP captures the bus |
| alu_drv | input | 1 | ALU result drives the bus and updates the zero flag |
| ira_drv | input | 1 | Zero-extended IR address field drives the bus |
| jz_go | input | 1 | Conditional jump on zero |
| bus_o | output | 8 | Current bus value |
| pc_o | output | 8 | Program counter |
| mar_o | output | 8 | Memory address register |
| ir_o | output | 8 | Instruction register |
| acc_o | output | 8 | Accumulator |
| opcode_o | output | 4 | IR upper nibble |
| zero_o | output | 1 | Zero flag |

## Verification
The bench builds the block with its default 8-bit data width and 4-bit address field, and passes its own 16-byte RAM image. That image holds a load instruction, a jump-on-zero and operand bytes at fixed spots, so the fetch, load, taken jump and not-taken jump all follow from real instruction bytes. With an 8-bit PC and a 4-bit RAM index, stepping PC past 15 shows the upper MAR bits being ignored in RAM addressing. A subtraction that goes negative shows the modulo-256 wrap.

// File: rtl/dp_src_pkg.sv
package dp_src_pkg;
    // Bus source indices, in falling priority
    localparam int unsigned SRC_PC   = 0;
    localparam int unsigned SRC_MEM  = 1;
    localparam int unsigned SRC_IRA  = 2;
    localparam int unsigned SRC_ACC  = 3;
    localparam int unsigned SRC_ALU  = 4;
    localparam int unsigned NUM_SRC  = 5;
endpackage

// File: rtl/dp_bus_arbiter.sv
module dp_bus_arbiter #(
    parameter int unsigned W    = 8,
    parameter int unsigned NSRC = 5
) (
    input  logic [NSRC-1:0] drv_en,
    input  logic [W-1:0]    drv_val [NSRC],
    output logic [W-1:0]    bus
);
    // Lowest index wins; nothing active leaves the bus at zero
    always_comb begin
        bus = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (drv_en[i]) begin
                bus = drv_val[i];
            end
        end
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] diff,
    output logic         is_zero
);
    always_comb begin
        diff    = lhs - rhs;
        is_zero = (diff == '0);
    end
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
    parameter int unsigned AW = 4,
    parameter int unsigned W  = 8,
    localparam int unsigned DEPTH = 2 ** AW,
    parameter logic [DEPTH*W-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT[i*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned DEPTH = 2 ** ADDR_W,
    parameter logic [DEPTH*DATA_W-1:0] RAM_INIT =
        128'h00000007_00000300_005AA900_0000A51C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_drv,
    input  logic              pc_step,
    input  logic              mar_ld,
    input  logic              mem_drv,
    input  logic              mem_wr,
    input  logic              ir_ld,
    input  logic              acc_ld,
    input  logic              acc_drv,
    input  logic              tmp_ld,
    input  logic              alu_drv,
    input  logic              ira_drv,
    input  logic              jz_go,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] mar_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-ADDR_W-1:0] opcode_o,
    output logic              zero_o
);
    import dp_src_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] mar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] tmp;
        logic              zero;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic [DATA_W-1:0]  bus;
    logic [DATA_W-1:0]  mem_rd;
    logic [DATA_W-1:0]  ira_ext;
    logic [DATA_W-1:0]  alu_diff;
    logic               alu_zero;
    logic [NUM_SRC-1:0] drv_en;
    logic [DATA_W-1:0]  drv_val [NUM_SRC];

    assign ira_ext = DATA_W'(st_q.ir[ADDR_W-1:0]);

    always_comb begin
        drv_en          = '0;
        drv_en[SRC_PC]  = pc_drv;
        drv_en[SRC_MEM] = mem_drv;
        drv_en[SRC_IRA] = ira_drv;
        drv_en[SRC_ACC] = acc_drv;
        drv_en[SRC_ALU] = alu_drv;
        drv_val[SRC_PC]  = st_q.pc;
        drv_val[SRC_MEM] = mem_rd;
        drv_val[SRC_IRA] = ira_ext;
        drv_val[SRC_ACC] = st_q.acc;
        drv_val[SRC_ALU] = alu_diff;
    end

    dp_bus_arbiter #(.W(DATA_W), .NSRC(NUM_SRC)) u_arb (
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .bus     (bus)
    );

    dp_alu #(.W(DATA_W)) u_alu (
        .lhs     (st_q.acc),
        .rhs     (st_q.tmp),
        .diff    (alu_diff),
        .is_zero (alu_zero)
    );

    dp_ram #(.AW(ADDR_W), .W(DATA_W), .INIT(RAM_INIT)) u_ram (
        .clk   (clk),
        .we    (mem_wr & ~rst),
        .addr  (st_q.mar[ADDR_W-1:0]),
        .wdata (bus),
        .rdata (mem_rd)
    );

    always_comb begin
        st_d = st_q;
        if (mar_ld)  st_d.mar  = bus;
        if (ir_ld)   st_d.ir   = bus;
        if (acc_ld)  st_d.acc  = bus;
        if (tmp_ld)  st_d.tmp  = bus;
        if (alu_drv) st_d.zero = alu_zero;
        if (jz_go) begin
            st_d.pc = st_q.zero ? ira_ext : st_q.pc + 1'b1;
        end else if (pc_step) begin
            st_d.pc = st_q.pc + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_o    = bus;
    assign pc_o     = st_q.pc;
    assign mar_o    = st_q.mar;
    assign ir_o     = st_q.ir;
    assign acc_o    = st_q.acc;
    assign opcode_o = st_q.ir[DATA_W-1:ADDR_W];
    assign zero_o   = st_q.zero;
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pc_drv,
    input logic              mem_drv,
    input logic              ira_drv,
    input logic              acc_drv,
    input logic              alu_drv,
    input logic              pc_step,
    input logic              jz_go,
    input logic [DATA_W-1:0] bus_o,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] ir_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              zero_o
);
    assert_one_driver_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_drv, mem_drv, ira_drv, acc_drv, alu_drv}));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && acc_o == '0 && ir_o == '0 && !zero_o));

    assert_ira_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (ira_drv && !pc_drv && !mem_drv) |-> (bus_o[DATA_W-1:ADDR_W] == '0));

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (pc_step && !jz_go) |=> (pc_o == DATA_W'($past(pc_o) + 1)));

    assert_zero_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !alu_drv |=> $stable(zero_o));

    assert_jz_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (jz_go && zero_o) |=> (pc_o == DATA_W'($past(ir_o[ADDR_W-1:0]))));

    assert_jz_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (jz_go && !zero_o) |=> (pc_o == DATA_W'($past(pc_o) + 1)));
endmodule

bind acc_bus_datapath dp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_drv  (pc_drv),
    .mem_drv (mem_drv),
    .ira_drv (ira_drv),
    .acc_drv (acc_drv),
    .alu_drv (alu_drv),
    .pc_step (pc_step),
    .jz_go   (jz_go),
    .bus_o   (bus_o),
    .pc_o    (pc_o),
    .ir_o    (ir_o),
    .acc_o   (acc_o),
    .zero_o  (zero_o)
);

// File: tb/sim_acc_bus_datapath.sv
module sim_acc_bus_datapath;
    localparam logic [127:0] IMG = 128'h00000007_00000300_005AA900_0000A51C;

    // Strobe bit positions for the bench's cycle task
    localparam int PCD = 0, STEP = 1, MARL = 2, MEMD = 3, MEMW = 4, IRL = 5;
    localparam int ACCL = 6, ACCD = 7, TMPL = 8, ALUD = 9, IRAD = 10, JZ = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] s = '0;
    logic [7:0] bus_o, pc_o, mar_o, ir_o, acc_o;
    logic [3:0] opcode_o;
    logic zero_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int m_pc, m_mar, m_ir, m_acc, m_tmp, m_zero;
    int m_mem [16];

    always #4 clk = ~clk;

    acc_bus_datapath #(.RAM_INIT(IMG)) u0 (
        .clk(clk), .rst(rst),
        .pc_drv(s[PCD]), .pc_step(s[STEP]), .mar_ld(s[MARL]), .mem_drv(s[MEMD]),
        .mem_wr(s[MEMW]), .ir_ld(s[IRL]), .acc_ld(s[ACCL]), .acc_drv(s[ACCD]),
        .tmp_ld(s[TMPL]), .alu_drv(s[ALUD]), .ira_drv(s[IRAD]), .jz_go(s[JZ]),
        .bus_o(bus_o), .pc_o(pc_o), .mar_o(mar_o), .ir_o(ir_o), .acc_o(acc_o),
        .opcode_o(opcode_o), .zero_o(zero_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int model_bus(input logic [11:0] v);
        if (v[PCD])  return m_pc;
        if (v[MEMD]) return m_mem[m_mar % 16];
        if (v[IRAD]) return m_ir % 16;
        if (v[ACCD]) return m_acc;
        if (v[ALUD]) return (m_acc - m_tmp) & 255;
        return 0;
    endfunction

    task automatic model_step(input logic r, input logic [11:0] v);
        int b = model_bus(v);
        int alu = (m_acc - m_tmp) & 255;
        if (r) begin
            m_pc = 0; m_mar = 0; m_ir = 0; m_acc = 0; m_tmp = 0; m_zero = 0;
            return;
        end
        if (v[MEMW]) m_mem[m_mar % 16] = b;
        if (v[JZ]) m_pc = m_zero ? (m_ir % 16) : ((m_pc + 1) & 255);
        else if (v[STEP]) m_pc = (m_pc + 1) & 255;
        if (v[MARL]) m_mar = b;
        if (v[IRL])  m_ir = b;
        if (v[ACCL]) m_acc = b;
        if (v[TMPL]) m_tmp = b;
        if (v[ALUD]) m_zero = (alu == 0);
    endtask

    task automatic chk_regs();
        chk("R5/R7 pc", pc_o, m_pc);
        chk("R4 ir", ir_o, m_ir);
        chk("R4 opcode", opcode_o, m_ir / 16);
        chk("R9 acc", acc_o, m_acc);
        chk("R9 mar", mar_o, m_mar);
        chk("R6 zero", zero_o, m_zero);
    endtask

    // Drive one cycle at a falling edge, check the bus, then the registers
    task automatic cyc(input logic r, input logic [11:0] v);
        rst = r;
        s = v;
        #1;
        if (!r) chk("R2 bus", bus_o, model_bus(v));
        model_step(r, v);
        @(negedge clk);
        chk_regs();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = IMG[i*8 +: 8];
        m_pc = 0; m_mar = 0; m_ir = 0; m_acc = 0; m_tmp = 0; m_zero = 0;
        @(negedge clk);
        cyc(1, 0);
        cyc(1, 0);
        // R1: reset state
        chk("R1 pc", pc_o, 0);
        chk("R1 acc", acc_o, 0);
        chk("R1 zero", zero_o, 0);
        // R4 fetch of 0x1C at address 0
        cyc(0, (1 << PCD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << IRL));
        chk("R4 fetched ir", ir_o, 8'h1C);
        // R3 address field on bus, zero-extended
        rst = 0; s = (1 << IRAD) | (1 << MARL); #1;
        chk("R3 ira bus", bus_o, 8'h0C);
        cyc(0, (1 << IRAD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << ACCL) | (1 << STEP));
        chk("R9 load acc", acc_o, 8'h07);
        chk("R5 pc after load", pc_o, 1);
        // Compare equal operands -> zero set (R6)
        cyc(0, (1 << ACCD) | (1 << TMPL));
        cyc(0, (1 << ALUD));
        chk("R6 equal sets zero", zero_o, 1);
        // Fetch 0xA5 at 1, jump taken to 5 (R7)
        cyc(0, (1 << PCD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << IRL));
        cyc(0, (1 << JZ) | (1 << STEP));
        chk("R7 taken", pc_o, 5);
        // Fetch 0xA9 at 5, load 0x03, compare unequal
        cyc(0, (1 << PCD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << IRL));
        cyc(0, (1 << IRAD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << ACCL));
        cyc(0, (1 << ALUD) | (1 << ACCL));
        chk("R6 wrap diff", acc_o, 8'hFC);
        chk("R6 unequal clears zero", zero_o, 0);
        cyc(0, (1 << JZ));
        chk("R7 not taken", pc_o, 6);
        // R8 store then read back
        cyc(0, (1 << IRAD) | (1 << MARL));
        cyc(0, (1 << ACCD) | (1 << MEMW));
        cyc(0, (1 << MEMD) | (1 << TMPL));
        cyc(0, (1 << ALUD));
        chk("R8 readback equal", zero_o, 1);
        // R8 upper MAR bits ignored: PC 22 reads address 6
        for (int i = 0; i < 16; i++) cyc(0, (1 << STEP));
        cyc(0, (1 << PCD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << ACCL));
        chk("R8 mar high bits", acc_o, 8'h5A);
        // R6 hold over idle cycles
        for (int i = 0; i < 3; i++) cyc(0, 0);
        chk("R6 zero held", zero_o, 1);
        // R1 reset keeps RAM: address 9 still 0xFC
        cyc(1, 0);
        for (int i = 0; i < 9; i++) cyc(0, (1 << STEP));
        cyc(0, (1 << PCD) | (1 << MARL));
        cyc(0, (1 << MEMD) | (1 << ACCL));
        chk("R1 ram kept", acc_o, 8'hFC);
        // Mixed strobe patterns, one driver at most
        for (int n = 0; n < 400; n++) begin
            logic [11:0] v;
            int k;
            v = 12'($urandom) & ~12'((1 << PCD) | (1 << MEMD) | (1 << IRAD) | (1 << ACCD) | (1 << ALUD));
            k = $urandom % 6;
            case (k)
                1: v[PCD]  = 1'b1;
                2: v[MEMD] = 1'b1;
                3: v[IRAD] = 1'b1;
                4: v[ACCD] = 1'b1;
                5: v[ALUD] = 1'b1;
                default: ;
            endcase
            cyc(0, v);
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule